// File: doc/BRIEF.md
# Cell Instruction Decode-Execute Unit

This unit takes one 11-bit instruction at a time, together with a separately supplied mode bit that widens the 3-bit opcode to sixteen operations, and carries it to completion. With the mode bit clear the instruction is a register update: it increments, decrements, shifts, copies or compares 8-bit registers and writes the result back. With the mode bit set the instruction is an action: the unit reports a typed, one-cycle action pulse (reproduce, instruction-pointer jump, cell move, attack or nothing) and, for the two jump forms, whether the jump is taken. The unit does not move any pointer and does not search for jump targets.

Each 4-bit register pointer names either one of eight local 8-bit registers or one of eight external registers. An external register is reached through a request/acknowledge port, and the unit stalls until the acknowledge arrives. Local register 0 holds an energy value that instructions can read but never change. Local register 7 holds the target location and is always visible on an output. A new instruction is accepted whenever the unit is idle or is completing the previous one, so that dependent instructions can run back to back.

Top module: `cell_exec`

## Requirements
- R1: Instruction bits [10:8] are the opcode, bits [7:4] the second register pointer and bits [3:0] the first (destination) pointer; pointer bit 3 set selects an external register and bits [2:0] give its number.
- R2: With the mode bit clear, opcode 000 adds one to the first register and 001 subtracts one, both wrapping modulo 256.
- R3: With the mode bit clear, opcode 010 shifts the first register left by one and 011 shifts it right by one, filling with zero.
- R4: With the mode bit clear, opcode 100 copies the second register into the first.
- R5: With the mode bit clear, opcodes 101, 110 and 111 compare the first register with the second as unsigned values (less, greater, equal) and write 0xFF to the first register when the condition holds and 0x00 otherwise.
- R6: Local register 0 reads as the energy value (0x5A by default) after reset, and every write addressed to it is discarded.
- R7: An external access raises `vreg_req_o` with the register number, a write flag and the write data held stable until `vreg_ack_i`; a read takes `vreg_rdata_i` in the acknowledge cycle. Within one instruction the first-pointer read comes before the second-pointer read, and an external write comes last.
- R8: With the mode bit set, the instruction completes with `act_valid_o` high for one cycle and `act_type_o` equal to 1 for opcode 000, 2 for 001 and 010, 3 for 011, 4 for 111 and 0 for 100, 101 and 110.
- R9: `jump_taken_o` is high with the action pulse of opcode 001 always, with that of opcode 010 only when the register named by the second pointer equals 0xFF, and never otherwise.
- R10: An action instruction (mode bit set) changes no register, local or external.
- R11: `target_o` always shows local register 7, which is 0x00 after reset.
- R12: An instruction is accepted on a clock edge where `start_i` and `ready_o` are both high; `ready_o` is high when idle and in the completion cycle; `done_o` pulses once per instruction, and an instruction with no external access completes in the cycle right after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Instruction offered |
| ghost_i | input | 1 | Mode bit extending the opcode |
| instr_i | input | 11 | Instruction word |
| ready_o | output | 1 | An offered instruction is taken at the next edge |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | Instruction completes this cycle |
| act_valid_o | output | 1 | Action instruction completes this cycle |
| act_type_o | output | 3 | Action type code |
| jump_taken_o | output | 1 | Jump action is taken |
| target_o | output | 8 | Contents of local register 7 |
| vreg_req_o | output | 1 | External register access request |
| vreg_we_o | output | 1 | Request is a write |
| vreg_idx_o | output | 3 | External register number |
| vreg_wdata_o | output | 8 | External write data |
| vreg_ack_i | input | 1 | External access completes |
| vreg_rdata_i | input | 8 | External read data |

## Verification
The completion of one instruction and the acceptance of the next share a cycle: the bench keeps `start_i` high with the next instruction while the previous one finishes, so the second instruction reads, in its execute cycle, a local register that the first wrote at the same edge it was accepted. Chains such as load, increment, decrement and compare on one register are issued this way and also with idle gaps, and every external write, action code and jump flag is compared with a bench model that applies the instructions strictly in order, with acknowledge delays of zero to two cycles.

// File: rtl/cell_exec_pkg.sv
package cell_exec_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned PTR_W  = 4;
  localparam int unsigned IDX_W  = PTR_W - 1;
  localparam int unsigned INS_W  = OP_W + 2 * PTR_W;
  localparam int unsigned N_REG  = 1 << IDX_W;
  localparam int unsigned ACT_W  = 3;

  localparam logic [OP_W-1:0] OP_INC = 3'd0;
  localparam logic [OP_W-1:0] OP_DEC = 3'd1;
  localparam logic [OP_W-1:0] OP_SHL = 3'd2;
  localparam logic [OP_W-1:0] OP_SHR = 3'd3;
  localparam logic [OP_W-1:0] OP_CPY = 3'd4;
  localparam logic [OP_W-1:0] OP_LT  = 3'd5;
  localparam logic [OP_W-1:0] OP_GT  = 3'd6;
  localparam logic [OP_W-1:0] OP_EQ  = 3'd7;

  localparam logic [OP_W-1:0] OP_REPRO  = 3'd0;
  localparam logic [OP_W-1:0] OP_JUMP   = 3'd1;
  localparam logic [OP_W-1:0] OP_JUMPC  = 3'd2;
  localparam logic [OP_W-1:0] OP_MOVE   = 3'd3;
  localparam logic [OP_W-1:0] OP_ATTACK = 3'd7;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE   = 3'd0,
    ACT_REPRO  = 3'd1,
    ACT_JUMP   = 3'd2,
    ACT_MOVE   = 3'd3,
    ACT_ATTACK = 3'd4
  } act_e;

  typedef struct packed {
    logic              gh;
    logic [OP_W-1:0]   op;
    logic [PTR_W-1:0]  p2;
    logic [PTR_W-1:0]  p1;
  } ins_t;

  typedef struct packed {
    logic reg_op;
    logic use_a;
    logic use_b;
    logic a_virt;
    logic b_virt;
    logic wr_virt;
    logic cond_jump;
    act_e act;
  } dec_t;
endpackage

// File: rtl/cell_decode.sv
module cell_decode
  import cell_exec_pkg::*;
(
  input  ins_t ins_i,
  output dec_t dec_o
);
  always_comb begin
    dec_o           = '0;
    dec_o.reg_op    = !ins_i.gh;
    dec_o.a_virt    = ins_i.p1[PTR_W-1];
    dec_o.b_virt    = ins_i.p2[PTR_W-1];
    dec_o.act       = ACT_NONE;
    if (!ins_i.gh) begin
      dec_o.use_a   = (ins_i.op != OP_CPY);
      dec_o.use_b   = (ins_i.op >= OP_CPY);
      dec_o.wr_virt = ins_i.p1[PTR_W-1];
    end else begin
      dec_o.use_b     = (ins_i.op == OP_JUMPC);
      dec_o.cond_jump = (ins_i.op == OP_JUMPC);
      unique case (ins_i.op)
        OP_REPRO:          dec_o.act = ACT_REPRO;
        OP_JUMP, OP_JUMPC: dec_o.act = ACT_JUMP;
        OP_MOVE:           dec_o.act = ACT_MOVE;
        OP_ATTACK:         dec_o.act = ACT_ATTACK;
        default:           dec_o.act = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cell_alu.sv
module cell_alu
  import cell_exec_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o,
  output logic            b_full_o
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};
  localparam logic [DW-1:0] ONE  = DW'(1);

  assign b_full_o = (b_i == ONES);

  always_comb begin
    unique case (op_i)
      OP_INC:  res_o = a_i + ONE;
      OP_DEC:  res_o = a_i - ONE;
      OP_SHL:  res_o = {a_i[DW-2:0], 1'b0};
      OP_SHR:  res_o = {1'b0, a_i[DW-1:1]};
      OP_CPY:  res_o = b_i;
      OP_LT:   res_o = (a_i < b_i)  ? ONES : '0;
      OP_GT:   res_o = (a_i > b_i)  ? ONES : '0;
      default: res_o = (a_i == b_i) ? ONES : '0;
    endcase
  end
endmodule

// File: rtl/cell_regfile.sv
module cell_regfile
  import cell_exec_pkg::*;
#(
  parameter int unsigned   DW          = 8,
  parameter logic [DW-1:0] ENERGY_INIT = 8'h5A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [DW-1:0]    rdata_a_o,
  output logic [DW-1:0]    rdata_b_o,
  output logic [DW-1:0]    target_o
);
  localparam int unsigned TGT = N_REG - 1;

  logic [DW-1:0] regs_q [N_REG];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    if (i == 0) begin : g_energy
      // energy: loaded at reset, never written
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[i] <= ENERGY_INIT;
      end
    end else begin : g_gpr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   regs_q[i] <= '0;
        else if (we_i && (waddr_i == IDX_W'(i)))       regs_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
  assign target_o  = regs_q[TGT];

  p_energy_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == '0) |=> (regs_q[0] == ENERGY_INIT));
endmodule

// File: rtl/cell_exec.sv
module cell_exec
  import cell_exec_pkg::*;
#(
  parameter int unsigned   DW          = 8,
  parameter logic [DW-1:0] ENERGY_INIT = 8'h5A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             ghost_i,
  input  logic [INS_W-1:0] instr_i,
  output logic             ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             act_valid_o,
  output logic [ACT_W-1:0] act_type_o,
  output logic             jump_taken_o,
  output logic [DW-1:0]    target_o,
  output logic             vreg_req_o,
  output logic             vreg_we_o,
  output logic [IDX_W-1:0] vreg_idx_o,
  output logic [DW-1:0]    vreg_wdata_o,
  input  logic             vreg_ack_i,
  input  logic [DW-1:0]    vreg_rdata_i
);
  typedef enum logic [2:0] {ST_IDLE, ST_RD_A, ST_RD_B, ST_EXEC, ST_WR} st_e;

  st_e           st_q, st_d;
  ins_t          ins_new, ins_q;
  dec_t          dec_new, dec_q;
  logic [DW-1:0] opa_q, opb_q, res_q;
  logic [DW-1:0] rf_a, rf_b, opa, opb, res;
  logic          b_full, finish, issue, rf_we;

  assign ins_new = {ghost_i, instr_i};

  cell_decode u_dec_new (.ins_i(ins_new), .dec_o(dec_new));
  cell_decode u_dec_cur (.ins_i(ins_q),   .dec_o(dec_q));

  function automatic st_e first_state(dec_t d);
    if (d.use_a && d.a_virt)      return ST_RD_A;
    else if (d.use_b && d.b_virt) return ST_RD_B;
    else                          return ST_EXEC;
  endfunction

  assign opa = dec_q.a_virt ? opa_q : rf_a;
  assign opb = dec_q.b_virt ? opb_q : rf_b;

  cell_alu #(.DW(DW)) u_alu (
    .op_i    (ins_q.op),
    .a_i     (opa),
    .b_i     (opb),
    .res_o   (res),
    .b_full_o(b_full)
  );

  assign rf_we = (st_q == ST_EXEC) && dec_q.reg_op && !dec_q.wr_virt;

  cell_regfile #(.DW(DW), .ENERGY_INIT(ENERGY_INIT)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we),
    .waddr_i  (ins_q.p1[IDX_W-1:0]),
    .wdata_i  (res),
    .raddr_a_i(ins_q.p1[IDX_W-1:0]),
    .raddr_b_i(ins_q.p2[IDX_W-1:0]),
    .rdata_a_o(rf_a),
    .rdata_b_o(rf_b),
    .target_o (target_o)
  );

  assign finish  = ((st_q == ST_EXEC) && !dec_q.wr_virt) || ((st_q == ST_WR) && vreg_ack_i);
  assign done_o  = finish;
  assign ready_o = (st_q == ST_IDLE) || finish;
  assign busy_o  = (st_q != ST_IDLE);
  assign issue   = start_i && ready_o;

  assign act_valid_o  = (st_q == ST_EXEC) && !dec_q.reg_op;
  assign act_type_o   = act_valid_o ? dec_q.act : ACT_NONE;
  assign jump_taken_o = act_valid_o && (dec_q.act == ACT_JUMP) && (!dec_q.cond_jump || b_full);

  assign vreg_req_o   = (st_q == ST_RD_A) || (st_q == ST_RD_B) || (st_q == ST_WR);
  assign vreg_we_o    = (st_q == ST_WR);
  assign vreg_idx_o   = (st_q == ST_RD_B) ? ins_q.p2[IDX_W-1:0] : ins_q.p1[IDX_W-1:0];
  assign vreg_wdata_o = (st_q == ST_WR) ? res_q : '0;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (issue) st_d = first_state(dec_new);
      ST_RD_A: if (vreg_ack_i) st_d = (dec_q.use_b && dec_q.b_virt) ? ST_RD_B : ST_EXEC;
      ST_RD_B: if (vreg_ack_i) st_d = ST_EXEC;
      ST_EXEC: begin
        if (dec_q.wr_virt) st_d = ST_WR;
        else               st_d = issue ? first_state(dec_new) : ST_IDLE;
      end
      ST_WR:   if (vreg_ack_i) st_d = issue ? first_state(dec_new) : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ins_q <= '0;
      opa_q <= '0;
      opb_q <= '0;
      res_q <= '0;
    end else begin
      st_q <= st_d;
      if (issue) ins_q <= ins_new;
      if (st_q == ST_RD_A && vreg_ack_i) opa_q <= vreg_rdata_i;
      if (st_q == ST_RD_B && vreg_ack_i) opb_q <= vreg_rdata_i;
      if (st_q == ST_EXEC) res_q <= res;
    end
  end

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vreg_req_o && !vreg_ack_i) |=> (vreg_req_o && $stable(vreg_idx_o) && $stable(vreg_we_o)
                                     && $stable(vreg_wdata_o)));

  p_act_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> (done_o && !vreg_req_o));

  p_taken_only_jump_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_taken_o |-> (act_valid_o && act_type_o == ACT_JUMP));

  p_action_keeps_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |=> $stable(target_o));

  p_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EXEC && dec_q.reg_op && ins_q.op >= OP_LT) |-> (res == '0 || res == {DW{1'b1}}));

  p_issue_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> busy_o);
endmodule

// File: tb/cell_exec_tb_top.sv
`timescale 1ns/1ps
module cell_exec_tb_top;
  localparam logic [7:0] E0    = 8'h5A;
  localparam int         NPROG = 700;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, ghost_i = 1'b0;
  logic [10:0] instr_i = '0;
  logic        ready_o, busy_o, done_o, act_valid_o, jump_taken_o;
  logic [2:0]  act_type_o, vreg_idx_o;
  logic [7:0]  target_o, vreg_wdata_o, vreg_rdata_i = '0;
  logic        vreg_req_o, vreg_we_o, vreg_ack_i = 1'b0;

  always #10 clk_i = ~clk_i;

  cell_exec dut_i (
    .clk_i, .rst_ni, .start_i, .ghost_i, .instr_i, .ready_o, .busy_o, .done_o,
    .act_valid_o, .act_type_o, .jump_taken_o, .target_o, .vreg_req_o, .vreg_we_o,
    .vreg_idx_o, .vreg_wdata_o, .vreg_ack_i, .vreg_rdata_i
  );

  int          checks = 0, errors = 0;
  logic        prog_gh  [NPROG];
  logic [10:0] prog_ins [NPROG];
  int          n_prog = 0;
  logic [7:0]  phys [8];
  logic [7:0]  vmem [8];

  // expectation of instruction in flight
  logic        c_gh;
  logic [2:0]  c_op;
  logic [3:0]  c_p1, c_p2;
  logic [7:0]  e_res;
  logic        e_taken;
  logic [2:0]  e_act;
  int          n_req, req_i, lat;
  logic        q_we [3];
  logic [2:0]  q_idx [3];

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic push(input logic gh, input logic [2:0] op, input logic [3:0] p2, input logic [3:0] p1);
    prog_gh[n_prog]  = gh;
    prog_ins[n_prog] = {op, p2, p1};
    n_prog++;
  endtask

  function automatic logic [7:0] f_res(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      3'd0: return a + 8'd1;
      3'd1: return a - 8'd1;
      3'd2: return {a[6:0], 1'b0};
      3'd3: return {1'b0, a[7:1]};
      3'd4: return b;
      3'd5: return (a < b) ? 8'hFF : 8'h00;
      3'd6: return (a > b) ? 8'hFF : 8'h00;
      default: return (a == b) ? 8'hFF : 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] f_act(input logic [2:0] op);
    case (op)
      3'd0: return 3'd1;
      3'd1, 3'd2: return 3'd2;
      3'd3: return 3'd3;
      3'd7: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic string f_tag(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [7:0] rd(input logic [3:0] p);
    return p[3] ? vmem[p[2:0]] : phys[p[2:0]];
  endfunction

  task automatic accept(input logic gh, input logic [10:0] ins);
    logic [7:0] a, b;
    logic na, nb;
    c_gh = gh; c_op = ins[10:8]; c_p2 = ins[7:4]; c_p1 = ins[3:0];
    a = rd(c_p1); b = rd(c_p2);
    e_res   = f_res(c_op, a, b);
    e_act   = f_act(c_op);
    e_taken = gh && ((c_op == 3'd1) || (c_op == 3'd2 && b == 8'hFF));
    na = !gh && c_op != 3'd4;
    nb = gh ? (c_op == 3'd2) : (c_op >= 3'd4);
    n_req = 0; req_i = 0; lat = 0;
    if (na && c_p1[3]) begin q_we[n_req] = 1'b0; q_idx[n_req] = c_p1[2:0]; n_req++; end
    if (nb && c_p2[3]) begin q_we[n_req] = 1'b0; q_idx[n_req] = c_p2[2:0]; n_req++; end
    if (!gh && c_p1[3]) begin q_we[n_req] = 1'b1; q_idx[n_req] = c_p1[2:0]; n_req++; end
  endtask

  initial begin
    int  ptr, wt;
    bit  acc, gap, inflight, stop;
    logic [3:0] rp1, rp2;
    for (int k = 0; k < 8; k++) begin phys[k] = (k == 0) ? E0 : 8'h00; vmem[k] = 8'($urandom(32'd4242)); end
    vmem[0] = 8'hFF; vmem[1] = 8'h80; vmem[2] = 8'h01; vmem[3] = 8'h7F;

    // directed: dump, wrap, shifts, compares, energy, jumps, all actions
    for (int k = 0; k < 8; k++) push(1'b0, 3'd4, 4'(k), 4'(8 + k));
    for (int k = 0; k < 8; k++) vmem[k] = (k < 4) ? vmem[k] : 8'(k * 17);
    push(0, 3'd4, 4'h8, 4'h1); push(0, 3'd0, 4'h0, 4'h1); push(0, 3'd1, 4'h0, 4'h1);
    push(0, 3'd4, 4'h9, 4'h2); push(0, 3'd2, 4'h0, 4'h2); push(0, 3'd4, 4'h9, 4'h2);
    push(0, 3'd3, 4'h0, 4'h2); push(0, 3'd4, 4'hB, 4'h3); push(0, 3'd5, 4'h2, 4'h3);
    push(0, 3'd4, 4'hB, 4'h3); push(0, 3'd6, 4'h2, 4'h3); push(0, 3'd7, 4'h4, 4'h4);
    push(1, 3'd2, 4'h4, 4'h0); push(1, 3'd2, 4'h3, 4'h0); push(1, 3'd2, 4'h8, 4'h0);
    push(1, 3'd2, 4'hA, 4'h0); push(0, 3'd0, 4'h0, 4'h0); push(0, 3'd1, 4'h0, 4'h0);
    push(0, 3'd4, 4'h8, 4'h0); push(0, 3'd4, 4'h0, 4'hF); push(0, 3'd4, 4'hA, 4'h7);
    for (int k = 0; k < 8; k++) push(1'b1, 3'(k), 4'h4, 4'h7);
    push(0, 3'd6, 4'h1, 4'hD); push(0, 3'd7, 4'hD, 4'hD); push(0, 3'd0, 4'h0, 4'h7);
    while (n_prog < NPROG - 8) begin
      rp1 = {($urandom % 4 == 0), 3'($urandom)};
      rp2 = {($urandom % 4 == 0), 3'($urandom)};
      push(1'($urandom), 3'($urandom), rp2, rp1);
    end
    for (int k = 0; k < 8; k++) push(1'b0, 3'd4, 4'(k), 4'(8 + k));

    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(ready_o && !busy_o && !done_o, "R12 reset", {ready_o, busy_o, done_o}, 3'b100);
    chk(!act_valid_o && !jump_taken_o && !vreg_req_o, "R8 reset", {act_valid_o, jump_taken_o, vreg_req_o}, 0);
    chk(target_o == 8'h00, "R11 reset", target_o, 0);

    ptr = 0; acc = 0; gap = 0; inflight = 0; stop = 0; wt = 0;
    for (int cyc = 0; cyc < 150000 && !stop; cyc++) begin
      @(negedge clk_i);
      if (acc) begin acc = 0; start_i = 1'b0; ptr++; gap = ($urandom % 4 == 0); end
      if (!start_i && ptr < n_prog) begin
        if (gap) gap = 0;
        else begin start_i = 1'b1; ghost_i = prog_gh[ptr]; instr_i = prog_ins[ptr]; end
      end
      if (inflight) lat++;
      // external register port
      vreg_ack_i = 1'b0;
      if (vreg_req_o) begin
        if (wt > 0) wt--;
        else begin
          if (!inflight || req_i >= n_req) chk(0, "R7 unexpected request", req_i, n_req);
          else begin
            chk(vreg_we_o == q_we[req_i], "R7 write flag", vreg_we_o, q_we[req_i]);
            chk(vreg_idx_o == q_idx[req_i], "R1 R7 register number", vreg_idx_o, q_idx[req_i]);
            if (vreg_we_o) begin
              chk(vreg_wdata_o == e_res, f_tag(c_op), vreg_wdata_o, e_res);
              vmem[vreg_idx_o] = vreg_wdata_o;
            end
            req_i++;
          end
          vreg_ack_i   = 1'b1;
          vreg_rdata_i = vmem[vreg_idx_o];
          wt = $urandom % 3;
        end
      end
      #1;
      if (target_o !== phys[7]) chk(0, "R11 target", target_o, phys[7]);
      if (done_o) begin
        if (!inflight) chk(0, "R12 spurious done", 1, 0);
        else begin
          chk(req_i == n_req, "R7 request count", req_i, n_req);
          chk(act_valid_o == c_gh, "R8 action valid", act_valid_o, c_gh);
          if (c_gh) begin
            chk(act_type_o == e_act, "R8 action type", act_type_o, e_act);
            chk(jump_taken_o == e_taken, "R9 jump taken", jump_taken_o, e_taken);
          end else begin
            chk(!jump_taken_o, "R9 no jump on register op", jump_taken_o, 0);
            if (!c_p1[3] && c_p1[2:0] != 3'd0) phys[c_p1[2:0]] = e_res;
          end
          if (n_req == 0) chk(lat == 1, "R12 latency", lat, 1);
          inflight = 0;
        end
      end
      if (inflight && lat > 100) begin chk(0, "R12 watchdog", lat, 100); stop = 1; end
      if (start_i && ready_o && !stop) begin
        accept(ghost_i, instr_i);
        inflight = 1; acc = 1;
      end
      if (ptr >= n_prog && !inflight && !acc) stop = 1;
    end
    if (ptr < n_prog || inflight) chk(0, "R12 watchdog end", ptr, n_prog);
    // final model state: energy and registers (R6 R10)
    chk(phys[0] == E0, "R6 energy model", phys[0], E0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule